// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a small word-addressed store in which every data word has a single presence tag beside it. A producer that writes a word marks it as holding data. A consumer can issue a synchronizing read. If the word holds data, the read completes as an ordinary read would. If it does not, the read is parked until a producer writes that word. The block then delivers the freshly written value. This makes the memory act as a scoreboard for values that are not yet computed. A consumer can hand out an address long before the value behind it exists.

Plain reads and writes are also supported. A plain read never waits and reports the tag along with the word. A clear operation on the write port empties one word. Reset empties every word. One parked read may exist at a time. While it waits, the read port refuses new requests.

Top module: `fe_tagged_mem`

## Requirements
- R1: After reset every word is empty and holds zero, `rd_ready` is 1, and `rsp_valid` and `wr_overwrite` are 0.
- R2: A write (`wr_valid`=1, `wr_clear`=0) stores `wr_data` and marks the word full. A later plain read returns that data with `rsp_full`=1.
- R3: A synchronizing read (`rd_sync`=1) accepted on a full word raises `rsp_valid` in the next cycle, with the stored data and `rsp_full`=1.
- R4: A synchronizing read accepted on an empty word produces no response, and `rd_ready` is 0 from the next cycle until the read is woken.
- R5: While a read is parked, a write to the parked address raises `rsp_valid` in the cycle after the write, with that write's data and `rsp_full`=1. `rd_ready` returns to 1 in that same cycle.
- R6: While a read is parked, writes and clears to other addresses give no response and keep the read parked.
- R7: A plain read (`rd_sync`=0) is answered in the next cycle with the stored data and the current tag, whether the word is full or empty.
- R8: A clear (`wr_valid`=1, `wr_clear`=1) empties one word and leaves its data unchanged. A later plain read returns the old data with `rsp_full`=0, and a later synchronizing read parks.
- R9: `wr_overwrite` is 1 in the cycle after a write that lands on a word that was already full. It is 0 after writes to empty words, after clears and in idle cycles.
- R10: A read accepted in the same cycle as a write or clear to the same address sees the result of that write or clear.
- R11: `wr_ready` is always 1, so a write or clear is accepted in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write port request |
| wr_ready | output | 1 | Write port ready, always 1 |
| wr_clear | input | 1 | 1: empty the word; 0: store `wr_data` and mark full |
| wr_addr | input | 5 | Write port word address |
| wr_data | input | 16 | Write data |
| wr_overwrite | output | 1 | Previous-cycle write hit a full word |
| rd_valid | input | 1 | Read port request |
| rd_ready | output | 1 | Read port ready, 0 while a read is parked |
| rd_sync | input | 1 | 1: synchronizing read; 0: plain read |
| rd_addr | input | 5 | Read port word address |
| rsp_valid | output | 1 | Read response strobe, one cycle |
| rsp_data | output | 16 | Read response data |
| rsp_full | output | 1 | Tag of the word as seen by the response |

## Verification
The read path is tried with plain reads of empty and full words. This separates the tag report from the data path. It is also tried with synchronizing reads of full words, which must answer at once, and of empty words, which must park. A parked read is then woken by a matching write after unrelated writes and clears have passed. This shows that only the parked address wakes it. Reads that collide in the same cycle with a write or clear to their address show whether the lookup sees the new state. A long random mix over a few addresses keeps words cycling between full and empty. That mix exercises overwrites, clears of parked words and back-to-back wakeups against a bench model.

// File: rtl/fe_pkg.sv
package fe_pkg;
   // source of the value carried by a read response
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_LOOK = 2'd1,
      SRC_WAKE = 2'd2
   } rsp_src_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned DEPTH      = 32,
   parameter bit          ZERO_ON_RST = 1'b1,
   localparam int unsigned ADDR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_clr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_was_full,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_full,
   output logic [DATA_W-1:0] lk_data
);
   logic [DEPTH-1:0]  tag_q;
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic              store;
   logic              same_word;

   assign store     = wr_en && !wr_clr;
   assign same_word = wr_en && (wr_addr == lk_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q <= '0;
      end else if (wr_en) begin
         tag_q[wr_addr] <= !wr_clr;
      end
   end

   generate
      if (ZERO_ON_RST) begin : g_mem_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (store) begin
               mem_q[wr_addr] <= wr_data;
            end
         end
      end else begin : g_mem_plain
         always_ff @(posedge clk) begin
            if (store) mem_q[wr_addr] <= wr_data;
         end
      end
   endgenerate

   // lookup sees the write of the same cycle (write-first)
   always_comb begin
      wr_was_full = tag_q[wr_addr];
      lk_full     = same_word ? !wr_clr : tag_q[lk_addr];
      lk_data     = (same_word && !wr_clr) ? wr_data : mem_q[lk_addr];
   end

   // R2
   fill_sets_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_clr) |=> tag_q[$past(wr_addr)]);
   // R8
   clear_drops_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_clr) |=> !tag_q[$past(wr_addr)]);
endmodule

// File: rtl/fe_wait_slot.sv
module fe_wait_slot #(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              park,
   input  logic [ADDR_W-1:0] park_addr,
   input  logic              fill,
   input  logic [ADDR_W-1:0] fill_addr,
   output logic              busy,
   output logic              wake,
   output logic [ADDR_W-1:0] wait_addr
);
   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;

   assign busy      = busy_q;
   assign wait_addr = addr_q;
   assign wake      = busy_q && fill && (fill_addr == addr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         addr_q <= '0;
      end else if (wake) begin
         busy_q <= 1'b0;
      end else if (park) begin
         busy_q <= 1'b1;
         addr_q <= park_addr;
      end
   end

   // R4
   single_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      park |-> !busy_q);
endmodule

// File: rtl/fe_tagged_mem.sv
module fe_tagged_mem #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned DEPTH       = 32,
   parameter bit          ZERO_ON_RST = 1'b1,
   localparam int unsigned ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic              wr_clear,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_overwrite,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic              rd_sync,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_full
);
   import fe_pkg::*;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("fe_tagged_mem: DATA_W must be at least 1");
      end
      if (DEPTH < 2 || !is_pow2(DEPTH)) begin : g_bad_depth
         $error("fe_tagged_mem: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic              lk_full;
   logic [DATA_W-1:0] lk_data;
   logic              was_full;
   logic              busy;
   logic              wake;
   logic [ADDR_W-1:0] wait_addr;
   logic              rd_fire;
   logic              park;
   logic              fill;
   rsp_src_e          src;

   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_data_q;
   logic              rsp_full_q;
   logic              ovw_q;

   assign wr_ready = 1'b1;
   assign rd_ready = !busy;
   assign rd_fire  = rd_valid && !busy;
   assign fill     = wr_valid && !wr_clear;
   assign park     = rd_fire && rd_sync && !lk_full;

   fe_tag_array #(
      .DATA_W     (DATA_W),
      .DEPTH      (DEPTH),
      .ZERO_ON_RST(ZERO_ON_RST)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_valid),
      .wr_clr     (wr_clear),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wr_was_full(was_full),
      .lk_addr    (rd_addr),
      .lk_full    (lk_full),
      .lk_data    (lk_data)
   );

   fe_wait_slot #(
      .ADDR_W(ADDR_W)
   ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .park     (park),
      .park_addr(rd_addr),
      .fill     (fill),
      .fill_addr(wr_addr),
      .busy     (busy),
      .wake     (wake),
      .wait_addr(wait_addr)
   );

   always_comb begin
      if (wake)                               src = SRC_WAKE;
      else if (rd_fire && (!rd_sync || lk_full)) src = SRC_LOOK;
      else                                    src = SRC_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
         rsp_full_q  <= 1'b0;
         ovw_q       <= 1'b0;
      end else begin
         rsp_valid_q <= (src != SRC_NONE);
         ovw_q       <= fill && was_full;
         case (src)
            SRC_WAKE: begin
               rsp_data_q <= wr_data;
               rsp_full_q <= 1'b1;
            end
            SRC_LOOK: begin
               rsp_data_q <= lk_data;
               rsp_full_q <= lk_full;
            end
            default: ;
         endcase
      end
   end

   assign rsp_valid    = rsp_valid_q;
   assign rsp_data     = rsp_data_q;
   assign rsp_full     = rsp_full_q;
   assign wr_overwrite = ovw_q;

   // R7
   plain_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready && !rd_sync) |=> (rsp_valid && rd_ready));
   // R3
   sync_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready && rd_sync) |=> ((rsp_valid && rsp_full) || !rd_ready));
   // R5
   wake_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_ready && wr_valid && !wr_clear && wr_addr == wait_addr)
      |=> (rsp_valid && rsp_full && rd_ready && rsp_data == $past(wr_data)));
   // R4
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_ready) |-> $past(rd_valid && rd_sync));
   // R9
   overwrite_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_overwrite |-> $past(wr_valid && !wr_clear));
endmodule

// File: tb/fe_tagged_mem_bench.sv
module fe_tagged_mem_bench;
   localparam int DW = 16;
   localparam int AW = 5;
   localparam int N  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0, wr_clear = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_valid = 1'b0, rd_sync = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          wr_ready, wr_overwrite, rd_ready, rsp_valid, rsp_full;
   logic [DW-1:0] rsp_data;

   int n_cmp = 0;
   int n_bad = 0;

   // bench model
   logic [DW-1:0] m_data [N];
   bit            m_full [N];
   bit            m_pend = 0;
   logic [AW-1:0] m_paddr = '0;
   bit            e_rv = 0, e_full = 0, e_ovw = 0;
   logic [DW-1:0] e_data = '0;
   string         e_tag = "R1";
   string         ctx = "R1 reset";

   always #4 clk = ~clk;

   fe_tagged_mem u_fe_tagged_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_clear(wr_clear),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_overwrite(wr_overwrite),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sync(rd_sync),
      .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_full(rsp_full)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit fill_hits_park(bit wv, bit wc, logic [AW-1:0] wa);
      return m_pend && wv && !wc && (wa == m_paddr);
   endfunction

   // check last cycle's results, advance the model, drive the next inputs
   task automatic step(input bit wv, input bit wc, input logic [AW-1:0] wa,
                       input logic [DW-1:0] wd, input bit rv, input bit rs,
                       input logic [AW-1:0] ra);
      bit ready_now;
      @(negedge clk);
      chk({ctx, " R11 wr_ready"}, wr_ready, 1);
      chk({ctx, " R4 rd_ready"}, rd_ready, !m_pend);
      chk({ctx, " ", e_tag, " rsp_valid"}, rsp_valid, e_rv);
      if (e_rv) begin
         chk({ctx, " ", e_tag, " rsp_data"}, rsp_data, e_data);
         chk({ctx, " ", e_tag, " rsp_full"}, rsp_full, e_full);
      end
      chk({ctx, " R9 wr_overwrite"}, wr_overwrite, e_ovw);

      ready_now = !m_pend;
      e_ovw = wv && !wc && m_full[wa];
      e_rv  = 0;
      e_tag = m_pend ? "R6" : "R4";
      if (fill_hits_park(wv, wc, wa)) begin
         e_rv = 1; e_data = wd; e_full = 1; e_tag = "R5";
         m_pend = 0;
      end
      if (wv) begin
         m_full[wa] = !wc;
         if (!wc) m_data[wa] = wd;
      end
      if (rv && ready_now) begin
         if (!rs || m_full[ra]) begin
            e_rv = 1; e_data = m_data[ra]; e_full = m_full[ra];
            e_tag = (wv && wa == ra) ? "R10" : (rs ? "R3" : "R7");
         end else begin
            m_pend = 1; m_paddr = ra;
         end
      end
      wr_valid = wv; wr_clear = wc; wr_addr = wa; wr_data = wd;
      rd_valid = rv; rd_sync = rs; rd_addr = ra;
   endtask

   task automatic idle();
      step(0, 0, '0, '0, 0, 0, '0);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin m_data[i] = '0; m_full[i] = 0; end
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, plain read of an untouched word
      ctx = "R1 reset";
      step(0, 0, 5'd0, 16'h0, 1, 0, 5'd5);
      idle();

      // R2: fill then plain read; R9 overwrite of a full word
      ctx = "R2 fill";
      step(1, 0, 5'd7, 16'hA5A5, 0, 0, '0);
      step(0, 0, '0, '0, 1, 0, 5'd7);
      step(1, 0, 5'd7, 16'h1234, 0, 0, '0);
      idle();

      // R3: synchronizing read of a full word
      ctx = "R3 hit";
      step(0, 0, '0, '0, 1, 1, 5'd7);
      idle();

      // R4, R6, R5: park on word 3, unrelated traffic, then wake
      ctx = "R4 park";
      step(0, 0, '0, '0, 1, 1, 5'd3);
      idle();
      ctx = "R6 other";
      step(1, 0, 5'd4, 16'h4444, 1, 1, 5'd4);
      step(1, 1, 5'd3, 16'h0, 0, 0, '0);
      step(1, 1, 5'd9, 16'h0, 0, 0, '0);
      ctx = "R5 wake";
      step(1, 0, 5'd3, 16'hBEEF, 0, 0, '0);
      step(0, 0, '0, '0, 1, 0, 5'd3);
      idle();

      // R8: clear keeps data, tag drops, sync read parks
      ctx = "R8 clear";
      step(1, 1, 5'd7, 16'h0, 0, 0, '0);
      step(0, 0, '0, '0, 1, 0, 5'd7);
      step(0, 0, '0, '0, 1, 1, 5'd7);
      idle();
      step(1, 0, 5'd7, 16'h7777, 0, 0, '0);
      idle();

      // R10: same-cycle write/clear with read to the same word
      ctx = "R10 collide";
      step(1, 0, 5'd12, 16'hC0DE, 1, 1, 5'd12);
      step(1, 1, 5'd12, 16'h0, 1, 0, 5'd12);
      step(1, 1, 5'd12, 16'h0, 1, 1, 5'd12);
      step(1, 0, 5'd12, 16'hD00D, 0, 0, '0);
      idle();

      // random mix over a few words
      ctx = "rnd";
      for (int k = 0; k < 4000; k++) begin
         step($urandom % 4 != 0, $urandom % 5 == 0, AW'($urandom % 8),
              DW'($urandom), $urandom % 2 == 1, $urandom % 3 != 0,
              AW'($urandom % 8));
      end
      idle();
      idle();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule